// File: doc/BRIEF.md
# Waveform Timer Channel

A single up-counting timer channel for waveform generation. A counter of parameterised width (16 bits by default) advances by one on each enabled cycle of a counting strobe. Each strobe is taken from either an internal prescaler tap or an external line, and the choice is a mode bit. The counter either runs through its whole range and wraps, or returns to zero when it matches compare register C. An optional one-shot setting turns the channel off when C matches.

Compare registers A, B and C raise sticky event flags. Matches on A and C also drive a waveform output pin through a programmable action: none, set, clear or toggle. Software uses a small register port to enable, disable and restart the channel. Through the same port it programs the compare values and the mode, and manages an interrupt mask with write-one-to-set and write-one-to-clear registers. Reading the status register returns the pending flags and clears them. The interrupt line is high while any pending flag has its mask bit set.

Top module: `tmr_wave_chan`

## Requirements
- R1: On reset the counter, the waveform pin, the interrupt line, the clock-on state, the flags, the mask, the mode and all compare registers are zero.
- R2: In free-running mode (mode bit 0 = 0), each counting step adds one to the counter. Stepping from the all-ones value wraps to zero and sets the overflow flag (status bit 3).
- R3: In up-to-C mode (mode bit 0 = 1), a counting step taken while the counter equals C loads zero instead of adding one.
- R4: With the one-shot bit set (mode bit 1), a counting step taken while the counter equals C turns the clock off. Later strobes leave the counter unchanged.
- R5: A write to the control register (address 0) acts on three bits. Bit 0 turns the clock on and bit 1 turns it off, and bit 1 wins if both are set. Bit 2 loads zero into the counter without changing the clock-on state. While the clock is off, strobes do not change the counter.
- R6: Mode bit 2 selects the strobe source: 0 for the internal tap, 1 for the external line. Strobes on the line that is not selected are ignored.
- R7: Status (address 5) holds flag bits A (bit 0), B (bit 1), C (bit 2) and overflow (bit 3), plus a live clock-on bit (bit 4). A compare flag is set by a counting step taken while the counter equals that compare register. Flags stay set until they are read.
- R8: A status read returns the flags and then clears them. The read data is valid in the cycle after the strobe. An event in the same cycle as the read leaves its flag set.
- R9: Writing ones to address 6 sets those mask bits, and writing ones to address 7 clears them. Either address reads back the mask. The interrupt line is high exactly when a pending flag has its mask bit set.
- R10: The waveform action codes are 0 none, 1 set, 2 clear and 3 toggle. The A action sits in mode bits 4:3 and the C action in mode bits 6:5. When A and C match on the same step, the C action decides the pin.
- R11: The mode register (address 1, 7 bits) and registers A, B and C (addresses 2, 3, 4) read back the last value written.
- R12: In free-running mode with A = 0 set to the set action and C = 0x8000 set to the clear action, the pin is high for exactly 32768 of every 65536 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_int_i | input | 1 | Counting strobe from the internal prescaler tap |
| tick_ext_i | input | 1 | Counting strobe from the external line |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CW | Write data |
| rdata_o | output | CW | Read data, valid the cycle after rd_en_i |
| count_o | output | CW | Current counter value |
| wave_o | output | 1 | Waveform output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
The in-line assertions check, on every cycle, the counter step rules, the zeroing in up-to-C mode, the one-shot stop, the restart command and the hold while the clock is off. They also check that a status read clears the flags, that an event in the same cycle survives the read, that the pin stays put without A or C events, and that the interrupt line follows flags and mask. Some behaviour is only visible at the ports over longer scenarios, so only the bench shows it. This covers the register readback encodings, the ignored strobe source, C winning over A on the pin, and the exact 50% duty over a full 65536-step period including the wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 4;   // A, B, C, overflow
  localparam int MODE_W = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0, A_MODE = 3'd1, A_RA = 3'd2, A_RB = 3'd3,
    A_RC   = 3'd4, A_STAT = 3'd5, A_IEN = 3'd6, A_IDIS = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0, ACT_SET = 2'd1, ACT_CLR = 2'd2, ACT_TGL = 2'd3
  } wave_act_e;

  typedef struct packed {
    wave_act_e rc_act;   // bits 6:5
    wave_act_e ra_act;   // bits 4:3
    logic      src_ext;  // bit 2
    logic      stop_rc;  // bit 1
    logic      upto_rc;  // bit 0
  } mode_t;

  // control register bit positions
  localparam int C_EN  = 0;
  localparam int C_DIS = 1;
  localparam int C_TRG = 2;

  function automatic logic apply_act(input wave_act_e act, input logic cur);
    case (act)
      ACT_SET: return 1'b1;
      ACT_CLR: return 1'b0;
      ACT_TGL: return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [CW-1:0]       wdata,
  input  logic [NFLAG:0]      stat_i,
  output logic [CW-1:0]       rdata,
  output mode_t               mode_o,
  output logic [CW-1:0]       ra_o,
  output logic [CW-1:0]       rb_o,
  output logic [CW-1:0]       rc_o,
  output logic [NFLAG-1:0]    mask_o,
  output logic [NFLAG-1:0]    mask_nxt_o
);
  localparam int PAD_M = CW - MODE_W;
  localparam int PAD_S = CW - NFLAG - 1;
  localparam int PAD_K = CW - NFLAG;

  logic [CW-1:0] rd_mux;

  always_comb begin
    mask_nxt_o = mask_o;
    if (wr_en && addr == A_IEN)  mask_nxt_o = mask_nxt_o | wdata[NFLAG-1:0];
    if (wr_en && addr == A_IDIS) mask_nxt_o = mask_nxt_o & ~wdata[NFLAG-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= '0;
      ra_o   <= '0;
      rb_o   <= '0;
      rc_o   <= '0;
      mask_o <= '0;
    end else begin
      mask_o <= mask_nxt_o;
      if (wr_en) begin
        case (reg_addr_e'(addr))
          A_MODE:  mode_o <= mode_t'(wdata[MODE_W-1:0]);
          A_RA:    ra_o   <= wdata;
          A_RB:    rb_o   <= wdata;
          A_RC:    rc_o   <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_e'(addr))
      A_MODE:         rd_mux = {{PAD_M{1'b0}}, mode_o};
      A_RA:           rd_mux = ra_o;
      A_RB:           rd_mux = rb_o;
      A_RC:           rd_mux = rc_o;
      A_STAT:         rd_mux = {{PAD_S{1'b0}}, stat_i};
      A_IEN, A_IDIS:  rd_mux = {{PAD_K{1'b0}}, mask_o};
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  a_r9_idis_all: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_IDIS && &wdata[NFLAG-1:0]) |=> (mask_o == '0));
  a_r9_ien_sets: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_IEN) |=> ((mask_o & $past(wdata[NFLAG-1:0])) == $past(wdata[NFLAG-1:0])));
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_int,
  input  logic             tick_ext,
  input  logic             ctrl_wr,
  input  logic [2:0]       ctrl_bits,
  input  mode_t            mode,
  input  logic [CW-1:0]    ra,
  input  logic [CW-1:0]    rb,
  input  logic [CW-1:0]    rc,
  output logic [CW-1:0]    cnt_o,
  output logic             clk_on_o,
  output logic [NFLAG-1:0] evt_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic tick_sel, step, rc_hit;

  assign tick_sel = mode.src_ext ? tick_ext : tick_int;
  assign step     = clk_on_o && tick_sel;
  assign rc_hit   = (cnt_o == rc);

  always_comb begin
    evt_o    = '0;
    evt_o[0] = step && (cnt_o == ra);
    evt_o[1] = step && (cnt_o == rb);
    evt_o[2] = step && rc_hit;
    evt_o[3] = step && (&cnt_o) && !(mode.upto_rc && rc_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o    <= '0;
      clk_on_o <= 1'b0;
    end else begin
      if (step) begin
        cnt_o <= (mode.upto_rc && rc_hit) ? '0 : cnt_o + ONE;
        if (mode.stop_rc && rc_hit) clk_on_o <= 1'b0;
      end
      if (ctrl_wr) begin
        if (ctrl_bits[C_TRG]) cnt_o <= '0;
        if (ctrl_bits[C_DIS])     clk_on_o <= 1'b0;
        else if (ctrl_bits[C_EN]) clk_on_o <= 1'b1;
      end
    end
  end

  a_r2_free_step: assert property (@(posedge clk) disable iff (rst)
    (step && !ctrl_wr && !mode.upto_rc) |=> (cnt_o - $past(cnt_o) == ONE));
  a_r3_rc_zero: assert property (@(posedge clk) disable iff (rst)
    (step && !ctrl_wr && mode.upto_rc && cnt_o == rc) |=> (cnt_o == '0));
  a_r4_oneshot_off: assert property (@(posedge clk) disable iff (rst)
    (step && !ctrl_wr && mode.stop_rc && cnt_o == rc) |=> !clk_on_o);
  a_r5_restart: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_bits == 3'b101) |=> (clk_on_o && cnt_o == '0));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!clk_on_o && !ctrl_wr) |=> $stable(cnt_o));
endmodule

// File: rtl/tmr_wave.sv
module tmr_wave
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      ra_evt,
  input  logic      rc_evt,
  input  wave_act_e ra_act,
  input  wave_act_e rc_act,
  output logic      wave_o
);
  logic w_a, w_c;

  always_comb begin
    w_a = ra_evt ? apply_act(ra_act, wave_o) : wave_o;
    w_c = rc_evt ? apply_act(rc_act, w_a)    : w_a;
  end

  always_ff @(posedge clk) begin
    if (rst) wave_o <= 1'b0;
    else     wave_o <= w_c;
  end

  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    !(ra_evt || rc_evt) |=> $stable(wave_o));
  a_r10_rc_set: assert property (@(posedge clk) disable iff (rst)
    (rc_evt && rc_act == ACT_SET) |=> wave_o);
  a_r10_rc_clr: assert property (@(posedge clk) disable iff (rst)
    (rc_evt && rc_act == ACT_CLR) |=> !wave_o);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] evt,
  input  logic             stat_rd,
  input  logic [NFLAG-1:0] mask_nxt,
  output logic [NFLAG-1:0] flags_o,
  output logic             irq_o
);
  logic [NFLAG-1:0] flags_d;

  assign flags_d = (stat_rd ? '0 : flags_o) | evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      flags_o <= flags_d;
      irq_o   <= |(flags_d & mask_nxt);
    end
  end

  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && evt == '0) |=> (flags_o == '0));
  a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && evt[2]) |=> flags_o[2]);
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

// File: rtl/tmr_wave_chan.sv
module tmr_wave_chan
  import tmr_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_int_i,
  input  logic              tick_ext_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     rdata_o,
  output logic [CW-1:0]     count_o,
  output logic              wave_o,
  output logic              irq_o
);
  mode_t            mode;
  logic [CW-1:0]    ra, rb, rc;
  logic [NFLAG-1:0] mask, mask_nxt, flags, evt;
  logic             clk_on, ctrl_wr, stat_rd;

  assign ctrl_wr = wr_en_i && addr_i == A_CTRL;
  assign stat_rd = rd_en_i && addr_i == A_STAT;

  tmr_regs #(.CW(CW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i),
    .wdata(wdata_i), .stat_i({clk_on, flags}), .rdata(rdata_o),
    .mode_o(mode), .ra_o(ra), .rb_o(rb), .rc_o(rc),
    .mask_o(mask), .mask_nxt_o(mask_nxt)
  );

  tmr_core #(.CW(CW)) core_i (
    .clk(clk), .rst(rst), .tick_int(tick_int_i), .tick_ext(tick_ext_i),
    .ctrl_wr(ctrl_wr), .ctrl_bits(wdata_i[2:0]), .mode(mode),
    .ra(ra), .rb(rb), .rc(rc),
    .cnt_o(count_o), .clk_on_o(clk_on), .evt_o(evt)
  );

  tmr_wave wave_i (
    .clk(clk), .rst(rst), .ra_evt(evt[0]), .rc_evt(evt[2]),
    .ra_act(mode.ra_act), .rc_act(mode.rc_act), .wave_o(wave_o)
  );

  tmr_irq irq_i (
    .clk(clk), .rst(rst), .evt(evt), .stat_rd(stat_rd),
    .mask_nxt(mask_nxt), .flags_o(flags), .irq_o(irq_o)
  );

  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(flags & mask));
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (count_o == '0 && !wave_o && !irq_o && !clk_on));
endmodule

// File: tb/tmr_wave_chan_tb_top.sv
module tmr_wave_chan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  // op codes: 0 write, 1 read+check, 2 internal ticks, 3 external ticks,
  // 4 counter check, 5 pin check {irq,wave}, 6 read without check
  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 70;
  localparam vec_t VEC [NV] = '{
    '{3'd0,3'd2,16'h0100,16'h0,4'd0},   // park A, B, C away
    '{3'd0,3'd3,16'h0100,16'h0,4'd0},
    '{3'd0,3'd4,16'h0100,16'h0,4'd0},
    '{3'd0,3'd1,16'h0000,16'h0,4'd0},
    '{3'd0,3'd0,16'h0005,16'h0,4'd0},   // enable + restart
    '{3'd4,3'd0,16'h0,16'h0000,4'd5},   // R5
    '{3'd1,3'd5,16'h0,16'h0010,4'd7},   // R7 clock-on bit
    '{3'd2,3'd0,16'd5,16'h0,4'd0},
    '{3'd4,3'd0,16'h0,16'd5,4'd2},      // R2
    '{3'd0,3'd2,16'h0007,16'h0,4'd0},
    '{3'd2,3'd0,16'd3,16'h0,4'd0},
    '{3'd4,3'd0,16'h0,16'd8,4'd2},      // R2
    '{3'd1,3'd5,16'h0,16'h0011,4'd7},   // R7 A flag
    '{3'd1,3'd5,16'h0,16'h0010,4'd8},   // R8 cleared
    '{3'd0,3'd0,16'h0002,16'h0,4'd0},   // disable
    '{3'd2,3'd0,16'd4,16'h0,4'd0},
    '{3'd4,3'd0,16'h0,16'd8,4'd5},      // R5 hold
    '{3'd1,3'd5,16'h0,16'h0000,4'd5},   // R5 clock off
    '{3'd0,3'd4,16'h0003,16'h0,4'd0},
    '{3'd0,3'd1,16'h0001,16'h0,4'd0},   // up-to-C
    '{3'd0,3'd0,16'h0005,16'h0,4'd0},
    '{3'd2,3'd0,16'd4,16'h0,4'd0},
    '{3'd4,3'd0,16'h0,16'd0,4'd3},      // R3
    '{3'd2,3'd0,16'd2,16'h0,4'd0},
    '{3'd4,3'd0,16'h0,16'd2,4'd3},      // R3
    '{3'd1,3'd5,16'h0,16'h0014,4'd7},   // R7 C flag
    '{3'd1,3'd1,16'h0,16'h0001,4'd11},  // R11
    '{3'd1,3'd2,16'h0,16'h0007,4'd11},
    '{3'd1,3'd4,16'h0,16'h0003,4'd11},
    '{3'd1,3'd3,16'h0,16'h0100,4'd11},
    '{3'd0,3'd6,16'h0004,16'h0,4'd0},
    '{3'd1,3'd6,16'h0,16'h0004,4'd9},   // R9 mask readback
    '{3'd2,3'd0,16'd2,16'h0,4'd0},
    '{3'd5,3'd0,16'h0,16'h0002,4'd9},   // R9 irq high
    '{3'd1,3'd5,16'h0,16'h0014,4'd8},
    '{3'd5,3'd0,16'h0,16'h0000,4'd9},   // R9 irq drops after read
    '{3'd0,3'd7,16'h00FF,16'h0,4'd0},
    '{3'd1,3'd6,16'h0,16'h0000,4'd9},   // R9
    '{3'd0,3'd1,16'h0003,16'h0,4'd0},   // one-shot
    '{3'd0,3'd0,16'h0005,16'h0,4'd0},
    '{3'd2,3'd0,16'd6,16'h0,4'd0},
    '{3'd4,3'd0,16'h0,16'd0,4'd4},      // R4
    '{3'd1,3'd5,16'h0,16'h0004,4'd4},   // R4 clock off, C flag
    '{3'd0,3'd1,16'h0061,16'h0,4'd0},   // C toggle
    '{3'd0,3'd0,16'h0005,16'h0,4'd0},
    '{3'd2,3'd0,16'd4,16'h0,4'd0},
    '{3'd5,3'd0,16'h0,16'h0001,4'd10},  // R10
    '{3'd2,3'd0,16'd4,16'h0,4'd0},
    '{3'd5,3'd0,16'h0,16'h0000,4'd10},
    '{3'd0,3'd1,16'h0021,16'h0,4'd0},   // C set
    '{3'd2,3'd0,16'd4,16'h0,4'd0},
    '{3'd5,3'd0,16'h0,16'h0001,4'd10},
    '{3'd0,3'd2,16'h0003,16'h0,4'd0},
    '{3'd0,3'd1,16'h0049,16'h0,4'd0},   // A set, C clear, same step
    '{3'd2,3'd0,16'd4,16'h0,4'd0},
    '{3'd5,3'd0,16'h0,16'h0000,4'd10},  // R10 C wins
    '{3'd6,3'd5,16'h0,16'h0,4'd0},
    '{3'd0,3'd1,16'h0004,16'h0,4'd0},   // external source
    '{3'd0,3'd0,16'h0005,16'h0,4'd0},
    '{3'd2,3'd0,16'd5,16'h0,4'd0},
    '{3'd4,3'd0,16'h0,16'd0,4'd6},      // R6 internal ignored
    '{3'd3,3'd0,16'd3,16'h0,4'd0},
    '{3'd4,3'd0,16'h0,16'd3,4'd6},      // R6
    '{3'd0,3'd0,16'h0004,16'h0,4'd0},   // trigger only
    '{3'd4,3'd0,16'h0,16'd0,4'd5},      // R5
    '{3'd3,3'd0,16'd2,16'h0,4'd0},
    '{3'd4,3'd0,16'h0,16'd2,4'd5},      // R5 still running
    '{3'd0,3'd0,16'h0007,16'h0,4'd0},   // disable wins
    '{3'd1,3'd5,16'h0,16'h0000,4'd5},   // R5
    '{3'd4,3'd0,16'h0,16'd0,4'd5}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic tick_int_i = 1'b0, tick_ext_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [CW-1:0] wdata_i = '0;
  logic [CW-1:0] rdata_o, count_o;
  logic wave_o, irq_o;
  int checks = 0, errors = 0;
  logic [CW-1:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_wave_chan #(.CW(CW)) dut_i (
    .clk(clk), .rst(rst), .tick_int_i(tick_int_i), .tick_ext_i(tick_ext_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .count_o(count_o), .wave_o(wave_o), .irq_o(irq_o)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a;
    @(negedge clk); rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic ticks(input bit ext, input int n);
    @(negedge clk);
    if (ext) tick_ext_i = 1'b1; else tick_int_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_ext_i = 1'b0; tick_int_i = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check(1, count_o, 0); check(1, wave_o, 0); check(1, irq_o, 0);
    rd(3'd5, rv); check(1, rv, 0);
    rd(3'd1, rv); check(1, rv, 0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        3'd0: wr(VEC[i].addr, VEC[i].data);
        3'd1: begin rd(VEC[i].addr, rv); check(int'(VEC[i].req), rv, VEC[i].exp); end
        3'd2: ticks(1'b0, int'(VEC[i].data));
        3'd3: ticks(1'b1, int'(VEC[i].data));
        3'd4: check(int'(VEC[i].req), count_o, VEC[i].exp);
        3'd5: check(int'(VEC[i].req), {irq_o, wave_o}, VEC[i].exp);
        default: rd(VEC[i].addr, rv);
      endcase
    end

    // R1: reset clears programmed state
    do_reset();
    check(1, count_o, 0); check(1, wave_o, 0);
    rd(3'd1, rv); check(1, rv, 0);
    rd(3'd6, rv); check(1, rv, 0);

    // R8: event in the same cycle as a status read keeps its flag
    wr(3'd4, 16'd3); wr(3'd1, 16'h0001); wr(3'd0, 16'h0005);
    ticks(1'b0, 3);
    rd(3'd5, rv);
    @(negedge clk); rd_en_i = 1'b1; addr_i = 3'd5; tick_int_i = 1'b1;
    @(negedge clk); rd_en_i = 1'b0; tick_int_i = 1'b0; rv = rdata_o;
    check(8, rv, 16'h0010);
    rd(3'd5, rv); check(8, rv, 16'h0014);

    // R12: 50% duty square wave over one full period, plus wrap (R2)
    do_reset();
    wr(3'd2, 16'h0000); wr(3'd4, 16'h8000); wr(3'd1, 16'h0048);
    wr(3'd0, 16'h0005);
    begin
      int hi = 0;
      @(negedge clk); tick_int_i = 1'b1;
      for (int k = 0; k < 65536; k++) begin
        @(negedge clk);
        if (wave_o) hi++;
      end
      tick_int_i = 1'b0;
      check(12, hi, 32768);
    end
    check(12, wave_o, 0);
    check(2, count_o, 0);
    rd(3'd5, rv); check(2, rv[3], 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule